// File: doc/BRIEF.md
# Transition-Triggered Spike Replay and Learning Gate

This block sits between the action population of a spiking value-learning array and its synapses. On every sampling tick it records each action spike line and each line of the one-hot state vector into its own delay line. It plays each line back a programmable number of ticks later, so the activity of the state just left is still present during the opening ticks of the state just entered.

The block also watches the sampled state vector for changes. Each change of state starts a single learning gate pulse, and only spikes that fall inside this pulse may take part in a weight update. The pulse width is programmable in ticks but can never exceed the replay delay. A new change of state during a pulse starts the pulse again at its full width.

A three-phase sequencer drives the gate. IDLE is the phase after reset, before any sample has been taken. ARMED means a reference sample exists and no pulse is running. GATE means a pulse is running. The named transitions are:
- prime: IDLE to ARMED, on the first tick.
- fire: ARMED to GATE, when a change arrives and the effective width is non-zero.
- restart: GATE to GATE, when a change arrives during a pulse.
- expire: GATE to ARMED, when the last tick of the pulse passes, or when a change arrives with an effective width of zero.

Top module: `spk_replay_gate`

## Requirements
- R1: When the effective delay is d, an action spike sampled on tick k appears on its `act_dly` bit for the interval that follows tick k+d. Several spikes in flight on one line keep their exact tick spacing.
- R2: Every bit of `state_oh` is replayed on `state_dly` with the same effective delay d as the action lines.
- R3: The effective delay equals `cfg_delay`, with two exceptions. A value of 0 acts as 1, and a value above MAX_DLY (default 16) acts as MAX_DLY.
- R4: The gate rises after a tick on which the sampled `state_oh` differs from the value sampled on the previous tick. It never rises at any other time.
- R5: The effective width is w = min(`cfg_width`, effective delay). The gate stays high for exactly w tick intervals after the changing tick. When w = 0, no pulse is produced.
- R6: A state change during a running pulse restarts the pulse at its full effective width.
- R7: During reset, and after release, all outputs are 0. The first tick after reset only captures the reference state and never starts a pulse.
- R8: Outputs change only on clock edges where `tick` is 1. On edges where `tick` is 0, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling tick enable |
| state_oh | input | N_STATE | One-hot current state |
| act_spk | input | N_ACT | One spike line per action |
| cfg_delay | input | $clog2(MAX_DLY+1) | Replay delay in ticks |
| cfg_width | input | $clog2(MAX_DLY+1) | Gate width in ticks |
| act_dly | output | N_ACT | Replayed action spikes |
| state_dly | output | N_STATE | Replayed state vector |
| gate | output | 1 | Learning gate pulse |

## Verification
All results are registered, so every output updates on the same edge as the tick that causes it. A replayed bit becomes visible after edge k+d, and the gate becomes visible after the edge of the changing tick. The pulse falls after edge k+w.

The bench model advances only on ticks. It captures its expected values on the same edge as the design does, including the delay and width in force at that tick. It compares these values against the outputs at the falling edge, half a period later, on every clock, including clocks where `tick` is 0.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_GATE  = 2'd2
    } gate_phase_e;
endpackage

// File: rtl/spk_cfg_clamp.sv
`timescale 1ns/1ps
module spk_cfg_clamp #(
    parameter int MAX_DLY = 16,
    localparam int CW = $clog2(MAX_DLY + 1)
) (
    input  logic [CW-1:0] cfg_delay,
    input  logic [CW-1:0] cfg_width,
    output logic [CW-1:0] d_eff,
    output logic [CW-1:0] w_eff
);
    localparam logic [CW-1:0] DMAX = CW'(MAX_DLY);
    localparam logic [CW-1:0] DMIN = CW'(1);

    always_comb begin
        if (cfg_delay == '0) begin
            d_eff = DMIN;
        end else if (cfg_delay > DMAX) begin
            d_eff = DMAX;
        end else begin
            d_eff = cfg_delay;
        end
        w_eff = (cfg_width > d_eff) ? d_eff : cfg_width;
    end
endmodule

// File: rtl/spk_delay_line.sv
`timescale 1ns/1ps
module spk_delay_line #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    input  logic [CW-1:0] dly,
    output logic          dout
);
    logic [DEPTH-1:0] stage;
    logic [SW-1:0]    tap;

    always_comb begin
        tap = SW'(dly - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
            dout  <= 1'b0;
        end else if (tick) begin
            dout  <= stage[tap];
            stage <= {stage[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/spk_change_detect.sv
`timescale 1ns/1ps
module spk_change_detect #(
    parameter int N_STATE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               primed,
    input  logic [N_STATE-1:0] state_oh,
    output logic               change
);
    logic [N_STATE-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (tick) begin
            ref_q <= state_oh;
        end
    end

    always_comb begin
        change = tick && primed && (state_oh != ref_q);
    end
endmodule

// File: rtl/spk_gate_fsm.sv
`timescale 1ns/1ps
module spk_gate_fsm
    import spk_pkg::*;
#(
    parameter int MAX_DLY = 16,
    localparam int CW = $clog2(MAX_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          change,
    input  logic [CW-1:0] w_eff,
    output logic          gate,
    output logic          primed
);
    gate_phase_e   ph, ph_n;
    logic [CW-1:0] left, left_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            left <= '0;
        end else begin
            ph   <= ph_n;
            left <= left_n;
        end
    end

    always_comb begin
        ph_n   = ph;
        left_n = left;
        unique case (ph)
            PH_IDLE: begin
                if (tick) ph_n = PH_ARMED;
            end
            PH_ARMED: begin
                if (change && w_eff != '0) begin
                    ph_n   = PH_GATE;
                    left_n = w_eff - CW'(1);
                end
            end
            PH_GATE: begin
                if (change) begin
                    if (w_eff != '0) begin
                        left_n = w_eff - CW'(1);
                    end else begin
                        ph_n = PH_ARMED;
                    end
                end else if (tick) begin
                    if (left == '0) begin
                        ph_n = PH_ARMED;
                    end else begin
                        left_n = left - CW'(1);
                    end
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_comb begin
        gate   = (ph == PH_GATE);
        primed = (ph != PH_IDLE);
    end
endmodule

// File: rtl/spk_replay_gate.sv
`timescale 1ns/1ps
module spk_replay_gate #(
    parameter int N_STATE = 4,
    parameter int N_ACT   = 2,
    parameter int MAX_DLY = 16,
    localparam int CW = $clog2(MAX_DLY + 1),
    localparam int NL = N_STATE + N_ACT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [N_STATE-1:0] state_oh,
    input  logic [N_ACT-1:0]   act_spk,
    input  logic [CW-1:0]      cfg_delay,
    input  logic [CW-1:0]      cfg_width,
    output logic [N_ACT-1:0]   act_dly,
    output logic [N_STATE-1:0] state_dly,
    output logic               gate
);
    logic [CW-1:0] d_eff;
    logic [CW-1:0] w_eff;
    logic          change;
    logic          primed;
    logic [NL-1:0] line_in;
    logic [NL-1:0] line_out;

    spk_cfg_clamp #(.MAX_DLY(MAX_DLY)) u_clamp (
        .cfg_delay (cfg_delay),
        .cfg_width (cfg_width),
        .d_eff     (d_eff),
        .w_eff     (w_eff)
    );

    assign line_in = {state_oh, act_spk};

    for (genvar g = 0; g < NL; g++) begin : g_line
        spk_delay_line #(.DEPTH(MAX_DLY)) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .din   (line_in[g]),
            .dly   (d_eff),
            .dout  (line_out[g])
        );
    end

    assign act_dly   = line_out[N_ACT-1:0];
    assign state_dly = line_out[NL-1:N_ACT];

    spk_change_detect #(.N_STATE(N_STATE)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .primed   (primed),
        .state_oh (state_oh),
        .change   (change)
    );

    spk_gate_fsm #(.MAX_DLY(MAX_DLY)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .change (change),
        .w_eff  (w_eff),
        .gate   (gate),
        .primed (primed)
    );
endmodule

// File: rtl/spk_replay_gate_chk.sv
`timescale 1ns/1ps
module spk_replay_gate_chk #(
    parameter int N_STATE = 4,
    parameter int N_ACT   = 2,
    parameter int MAX_DLY = 16,
    localparam int CW = $clog2(MAX_DLY + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [N_STATE-1:0] state_oh,
    input logic [CW-1:0]      cfg_delay,
    input logic [CW-1:0]      cfg_width,
    input logic [N_ACT-1:0]   act_dly,
    input logic [N_STATE-1:0] state_dly,
    input logic               gate
);
    logic [N_STATE-1:0] c_prev;
    logic               c_primed;
    logic               c_seen;
    logic [CW:0]        c_run;
    logic               c_trans;
    int                 c_dlim;
    int                 c_wlim;

    always_comb begin
        c_trans = tick && c_primed && (state_oh != c_prev);
        if (cfg_delay == '0)                 c_dlim = 1;
        else if (int'(cfg_delay) > MAX_DLY)  c_dlim = MAX_DLY;
        else                                 c_dlim = int'(cfg_delay);
        c_wlim = (int'(cfg_width) < c_dlim) ? int'(cfg_width) : c_dlim;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_prev   <= '0;
            c_primed <= 1'b0;
            c_seen   <= 1'b0;
            c_run    <= '0;
        end else if (tick) begin
            c_prev   <= state_oh;
            c_primed <= 1'b1;
            if (c_trans) begin
                c_seen <= 1'b1;
                c_run  <= (CW+1)'(1);
            end else if (gate) begin
                c_run  <= c_run + (CW+1)'(1);
            end else begin
                c_run  <= '0;
            end
        end
    end

    // R4: a rising gate always follows a sampled state change
    assert_gate_after_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(c_trans));

    // R7: no pulse before the first detected change
    assert_quiet_until_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !c_seen |-> !gate);

    // R5: pulse never lasts longer than the clamped width
    assert_width_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (int'(c_run) <= c_wlim));

    // R6: a change with non-zero width leaves the gate high
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_trans && c_wlim != 0) |=> gate);

    // R8: outputs hold on edges without a tick
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(gate) && $stable(act_dly) && $stable(state_dly)));
endmodule

bind spk_replay_gate spk_replay_gate_chk #(
    .N_STATE (N_STATE),
    .N_ACT   (N_ACT),
    .MAX_DLY (MAX_DLY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .state_oh  (state_oh),
    .cfg_delay (cfg_delay),
    .cfg_width (cfg_width),
    .act_dly   (act_dly),
    .state_dly (state_dly),
    .gate      (gate)
);

// File: tb/spk_replay_gate_bench.sv
`timescale 1ns/1ps
module spk_replay_gate_bench;
    localparam int NS  = 4;
    localparam int NA  = 2;
    localparam int MD  = 16;
    localparam int CW  = $clog2(MD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NS-1:0] state_oh = 4'b0001;
    logic [NA-1:0] act_spk = '0;
    logic [CW-1:0] cfg_delay = CW'(5);
    logic [CW-1:0] cfg_width = CW'(5);
    logic [NA-1:0] act_dly;
    logic [NS-1:0] state_dly;
    logic          gate;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    string tag_act  = "R1";
    string tag_gate = "R4";
    int cur_idx = 0;
    int tcount  = 0;

    always #4 clk = ~clk;

    spk_replay_gate #(.N_STATE(NS), .N_ACT(NA), .MAX_DLY(MD)) u_spk_replay_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .state_oh  (state_oh),
        .act_spk   (act_spk),
        .cfg_delay (cfg_delay),
        .cfg_width (cfg_width),
        .act_dly   (act_dly),
        .state_dly (state_dly),
        .gate      (gate)
    );

    // behavioural reference: history queue plus a remaining-ticks integer
    logic [NS+NA-1:0] hist[$];
    logic [NA-1:0]    exp_act = '0;
    logic [NS-1:0]    exp_st  = '0;
    bit               exp_gate = 1'b0;
    bit               m_primed = 1'b0;
    logic [NS-1:0]    m_prev  = '0;
    int               m_rem   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            exp_act = '0; exp_st = '0; exp_gate = 1'b0;
            m_primed = 1'b0; m_prev = '0; m_rem = 0;
        end else if (tick) begin
            int d, w;
            d = int'(cfg_delay);
            if (d == 0) d = 1;
            if (d > MD) d = MD;
            w = (int'(cfg_width) < d) ? int'(cfg_width) : d;
            hist.push_front({state_oh, act_spk});
            if (hist.size() > MD + 1) void'(hist.pop_back());
            if (hist.size() > d) begin
                exp_act = hist[d][NA-1:0];
                exp_st  = hist[d][NS+NA-1:NA];
            end else begin
                exp_act = '0;
                exp_st  = '0;
            end
            if (m_primed && state_oh != m_prev) m_rem = w;
            else if (m_rem > 0) m_rem = m_rem - 1;
            m_prev = state_oh;
            m_primed = 1'b1;
            exp_gate = (m_rem > 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (act_dly !== exp_act) begin
                fails++;
                $display("FAIL %s act_dly actual=%b expected=%b t=%0t", tag_act, act_dly, exp_act, $time);
            end
            checks++;
            if (state_dly !== exp_st) begin
                fails++;
                $display("FAIL R2 state_dly actual=%b expected=%b t=%0t", state_dly, exp_st, $time);
            end
            checks++;
            if (gate !== exp_gate) begin
                fails++;
                $display("FAIL %s gate actual=%b expected=%b t=%0t", tag_gate, gate, exp_gate, $time);
            end
        end
    end

    task automatic drive(input int n, input bit irregular, input int hold);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            tick = irregular ? 1'($urandom % 2) : 1'b1;
            act_spk = NA'($urandom) & NA'($urandom);
            if (tick) begin
                tcount++;
                if (hold > 0 && (tcount % hold) == 0) begin
                    cur_idx = (cur_idx + 1 + int'($urandom % (NS - 1))) % NS;
                    state_oh = NS'(1) << cur_idx;
                end
            end
        end
    endtask

    task automatic set_cfg(input int d, input int w);
        drive(40, 1'b0, 0);
        @(posedge clk);
        #2;
        tick = 1'b0;
        cfg_delay = CW'(d);
        cfg_width = CW'(w);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (act_dly !== '0 || state_dly !== '0 || gate !== 1'b0) begin
            fails++;
            $display("FAIL R7 reset outputs actual=%b/%b/%b expected=0/0/0", act_dly, state_dly, gate);
        end
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        // first ticks after reset with a steady state: no pulse (R7)
        tag_gate = "R7";
        drive(12, 1'b0, 0);
        // main replay and gate, d=5 w=5
        tag_gate = "R4";
        drive(200, 1'b0, 8);
        // irregular ticks: outputs hold between ticks (R8)
        tag_act = "R8";
        drive(200, 1'b1, 7);
        // width larger than delay clamps (R5)
        tag_act = "R1";
        tag_gate = "R5";
        set_cfg(3, 9);
        drive(150, 1'b0, 7);
        // zero width: no pulse (R5)
        set_cfg(4, 0);
        drive(120, 1'b0, 6);
        // delay clamps at both ends (R3)
        tag_act = "R3";
        set_cfg(0, 2);
        drive(120, 1'b0, 5);
        set_cfg(31, 20);
        drive(250, 1'b0, 20);
        // restarts during a running pulse (R6)
        tag_act = "R1";
        tag_gate = "R6";
        set_cfg(6, 6);
        drive(150, 1'b0, 2);
        drive(60, 1'b1, 3);
        drive(30, 1'b0, 0);
        finish_run();
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule